// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block takes configuration words arriving on a three-wire serial link (serial clock, serial data, load strobe) and turns them into four parallel register images for the rest of the chip. The three serial lines are asynchronous to the system clock. Each line is passed through a multi-stage synchronizer, and edges of the serial clock and the load strobe are detected in the system clock domain.

Each detected rising edge of the serial clock shifts the current data bit into a 24-bit shift register. The first bit sent becomes the most significant bit of the word. When a rising edge of the load strobe is detected, the two least significant bits of the word (the last two bits sent) choose one of four latches. The remaining 22 upper bits are stored in that latch, and the other three latches keep their values. While the load strobe is high the shift register is frozen. It keeps its word, so a later strobe transfers that same word again.

Top module: `serial_cfg_loader`

## Requirements
- R1: While rst_n is low, all four latch images in cfg_bank and the shift register read zero.
- R2: Each rising edge of ser_clk (seen while ser_ld is low) shifts ser_dat into the word; the first bit sent ends at word bit 23 and the last at word bit 0.
- R3: On a rising edge of ser_ld, word bits [1:0] give the latch index k (0 to 3), and word bits [23:2] are written to cfg_bank[k] (bits [22*k+21 : 22*k] of the port).
- R4: A transfer leaves the three latches not addressed by word bits [1:0] unchanged.
- R5: cfg_bank changes only on a rising edge of ser_ld. Shifting without a strobe, holding ser_ld high, and the falling edge of ser_ld leave it unchanged.
- R6: Rising edges of ser_clk while ser_ld is high do not alter the shift register, so a following strobe transfers the word held before ser_ld went high.
- R7: A latch update appears on cfg_bank after the third rising edge of clk following the rise of ser_ld, and not after the second.
- R8: When more than 24 bits are shifted before a strobe, only the last 24 bits sent form the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous; data taken on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_ld | input | 1 | Load strobe; rising edge commits the word to a latch |
| cfg_bank | output | 88 | Four 22-bit latch images, latch k at bits [22*k+21 : 22*k] |

## Verification
Each serial line reaches its last synchronizer flop two system clock edges after it changes, and the registered result takes one more edge. A latch image is therefore due on the third rising edge of clk after ser_ld rises, and a shifted bit is due on the third edge after ser_clk rises. The bench drives every input at a falling edge of clk. It checks the latch bank one time unit after the second rising edge (old contents still expected) and again after the third (new contents expected). Every serial clock level is held for four system cycles and every strobe level for six, so each shift and transfer has completed before the next stimulus and before any check that is meant to show that nothing changed.

// File: rtl/scl_pkg.sv
`timescale 1ns/1ps
package scl_pkg;
   // Default geometry of the serial loader
   localparam int unsigned SCL_WORD_W_DEF = 24;
   localparam int unsigned SCL_ADDR_W_DEF = 2;
   localparam int unsigned SCL_SYNC_DEF   = 2;

   // Bit positions of the lines inside the synchronizer bus
   localparam int unsigned SCL_LN_CLK = 0;
   localparam int unsigned SCL_LN_LD  = 1;
   localparam int unsigned SCL_LN_DAT = 2;
   localparam int unsigned SCL_LINES  = 3;
   localparam int unsigned SCL_EDGED  = 2;
endpackage

// File: rtl/scl_edge_sync.sv
`timescale 1ns/1ps
module scl_edge_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned EDGES  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_o,
   output logic [EDGES-1:0] rise_o
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("scl_edge_sync: STAGES must be at least 2");
   end
   if (EDGES > WIDTH || EDGES == 0) begin : g_bad_edges
      $error("scl_edge_sync: EDGES must be in 1..WIDTH");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= async_in;
         for (int k = 1; k < STAGES; k++) begin
            chain_q[k] <= chain_q[k-1];
         end
      end
   end

   assign sync_o = chain_q[LAST];

   // Edge detection only on the low EDGES lines
   logic [EDGES-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= chain_q[LAST][EDGES-1:0];
   end

   for (genvar e = 0; e < EDGES; e++) begin : g_edge
      assign rise_o[e] = chain_q[LAST][e] & ~prev_q[e];
   end

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0)); // R2
endmodule

// File: rtl/scl_shifter.sv
`timescale 1ns/1ps
module scl_shifter #(
   parameter int unsigned WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_stb,
   input  logic              hold,
   input  logic              bit_in,
   output logic [WORD_W-1:0] word_o
);
   if (WORD_W < 2) begin : g_bad_width
      $error("scl_shifter: WORD_W must be at least 2");
   end

   logic [WORD_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (shift_stb && !hold) begin
         word_q <= {word_q[WORD_W-2:0], bit_in};
      end
   end

   assign word_o = word_q;

   AST_FROZEN_WHILE_LD: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(word_o)); // R6
   AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_stb |=> $stable(word_o)); // R2
endmodule

// File: rtl/scl_latch_bank.sv
`timescale 1ns/1ps
module scl_latch_bank #(
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned PAYLOAD_W = 22,
   localparam int unsigned NUM_LATCH = 1 << ADDR_W
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_stb,
   input  logic [ADDR_W-1:0]                   wr_addr,
   input  logic [PAYLOAD_W-1:0]                wr_data,
   output logic [NUM_LATCH-1:0][PAYLOAD_W-1:0] bank_o
);
   if (ADDR_W == 0 || PAYLOAD_W == 0) begin : g_bad_geom
      $error("scl_latch_bank: ADDR_W and PAYLOAD_W must be non-zero");
   end

   for (genvar gi = 0; gi < NUM_LATCH; gi++) begin : g_latch
      logic [PAYLOAD_W-1:0] img_q;
      logic                 sel;

      assign sel = wr_stb && (wr_addr == ADDR_W'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   img_q <= '0;
         else if (sel) img_q <= wr_data;
      end

      assign bank_o[gi] = img_q;

      AST_UNSEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_stb && wr_addr != ADDR_W'(gi)) |=> $stable(bank_o[gi])); // R4
   end

   AST_BANK_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(bank_o)); // R5
endmodule

// File: rtl/serial_cfg_loader.sv
`timescale 1ns/1ps
module serial_cfg_loader
   import scl_pkg::*;
#(
   parameter int unsigned WORD_W      = SCL_WORD_W_DEF,
   parameter int unsigned ADDR_W      = SCL_ADDR_W_DEF,
   parameter int unsigned SYNC_STAGES = SCL_SYNC_DEF,
   localparam int unsigned PAYLOAD_W  = WORD_W - ADDR_W,
   localparam int unsigned NUM_LATCH  = 1 << ADDR_W
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                ser_clk,
   input  logic                                ser_dat,
   input  logic                                ser_ld,
   output logic [NUM_LATCH-1:0][PAYLOAD_W-1:0] cfg_bank
);
   if (WORD_W <= ADDR_W) begin : g_bad_word
      $error("serial_cfg_loader: WORD_W must exceed ADDR_W");
   end

   logic [SCL_LINES-1:0] line_raw;
   logic [SCL_LINES-1:0] line_sync;
   logic [SCL_EDGED-1:0] line_rise;

   always_comb begin
      line_raw             = '0;
      line_raw[SCL_LN_CLK] = ser_clk;
      line_raw[SCL_LN_LD]  = ser_ld;
      line_raw[SCL_LN_DAT] = ser_dat;
   end

   scl_edge_sync #(
      .WIDTH  (SCL_LINES),
      .EDGES  (SCL_EDGED),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (line_raw),
      .sync_o   (line_sync),
      .rise_o   (line_rise)
   );

   logic              clk_lvl, ld_lvl, dat_lvl;
   logic              clk_rise, ld_rise;
   logic [WORD_W-1:0] shift_word;

   assign clk_lvl  = line_sync[SCL_LN_CLK];
   assign ld_lvl   = line_sync[SCL_LN_LD];
   assign dat_lvl  = line_sync[SCL_LN_DAT];
   assign clk_rise = line_rise[SCL_LN_CLK];
   assign ld_rise  = line_rise[SCL_LN_LD];

   scl_shifter #(
      .WORD_W (WORD_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_stb (clk_rise),
      .hold      (ld_lvl),
      .bit_in    (dat_lvl),
      .word_o    (shift_word)
   );

   scl_latch_bank #(
      .ADDR_W    (ADDR_W),
      .PAYLOAD_W (PAYLOAD_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (ld_rise),
      .wr_addr (shift_word[ADDR_W-1:0]),
      .wr_data (shift_word[WORD_W-1:ADDR_W]),
      .bank_o  (cfg_bank)
   );

   AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(shift_word) |-> $past(clk_lvl && !ld_lvl)); // R6
   AST_LOAD_NEEDS_LD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_bank) |-> $past(ld_lvl)); // R5
endmodule

// File: tb/serial_cfg_loader_test.sv
`timescale 1ns/1ps
module serial_cfg_loader_test;
   localparam int PAY = 22;
   localparam int NL  = 4;
   localparam int BW  = PAY * NL;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
   logic [NL-1:0][PAY-1:0] cfg_bank;
   logic [NL-1:0][PAY-1:0] exp_bank;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #2.5 clk = ~clk;

   serial_cfg_loader uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .ser_clk  (ser_clk),
      .ser_dat  (ser_dat),
      .ser_ld   (ser_ld),
      .cfg_bank (cfg_bank)
   );

   task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      ser_dat = b;
      ser_clk = 1'b0;
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
   endtask

   task automatic send_bits(input logic [31:0] w, input int nbits);
      for (int i = nbits - 1; i >= 0; i--) send_bit(w[i]);
      repeat (4) @(negedge clk);
   endtask

   // Rise ser_ld, check R7 timing, then hold and drop it (R5)
   task automatic strobe_check(input logic [BW-1:0] new_exp, input string req);
      @(negedge clk);
      ser_ld = 1'b1;
      @(posedge clk);
      @(posedge clk);
      #1 chk("R7 update not visible after second edge", cfg_bank, exp_bank);
      @(posedge clk);
      #1 chk(req, cfg_bank, new_exp);
      exp_bank = new_exp;
      repeat (6) @(negedge clk);
      chk("R5 ser_ld held high", cfg_bank, exp_bank);
      ser_ld = 1'b0;
      repeat (6) @(negedge clk);
      chk("R5 ser_ld falling edge", cfg_bank, exp_bank);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk("R1 reset image", cfg_bank, '0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 after release", cfg_bank, '0);
      exp_bank = '0;
   endtask

   task automatic t_each_latch;
      logic [PAY-1:0]         pay;
      logic [NL-1:0][PAY-1:0] nx;
      for (int a = 0; a < NL; a++) begin
         case (a)
            0: pay = 22'h3C0001;
            1: pay = 22'h00F00E;
            2: pay = 22'h155555;
            default: pay = 22'h2AAAA9;
         endcase
         nx = exp_bank;
         nx[a] = pay;
         send_bits({8'h00, pay, 2'(a)}, 24);
         strobe_check(nx, "R2 R3 R4 addressed write");
      end
   endtask

   task automatic t_no_strobe;
      send_bits({8'h00, 22'h3FFFFF, 2'd1}, 24);
      repeat (8) @(negedge clk);
      chk("R5 shifting without strobe", cfg_bank, exp_bank);
   endtask

   task automatic t_ignore_while_ld;
      logic [NL-1:0][PAY-1:0] nx;
      nx = exp_bank;
      nx[2] = 22'h0ABCDE;
      send_bits({8'h00, 22'h0ABCDE, 2'd2}, 24);
      strobe_check(nx, "R3 R4 overwrite latch 2");
      @(negedge clk);
      ser_ld = 1'b1;
      repeat (6) @(negedge clk);
      chk("R6 rewrite same word on second strobe", cfg_bank, exp_bank);
      send_bits({8'h00, 22'h12345A, 2'd3}, 24);
      chk("R6 bits during ser_ld high", cfg_bank, exp_bank);
      ser_ld = 1'b0;
      repeat (6) @(negedge clk);
      chk("R6 after ser_ld low", cfg_bank, exp_bank);
      ser_ld = 1'b1;
      repeat (6) @(negedge clk);
      chk("R6 strobe transfers held word", cfg_bank, exp_bank);
      ser_ld = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic t_long_word;
      logic [NL-1:0][PAY-1:0] nx;
      nx = exp_bank;
      nx[0] = 22'h1F0F0F;
      send_bits({2'b00, 6'b101101, 22'h1F0F0F, 2'd0}, 30);
      strobe_check(nx, "R8 only last 24 bits kept");
   endtask

   initial begin
      exp_bank = '0;
      t_reset();
      t_each_latch();
      t_no_strobe();
      t_ignore_while_ld();
      t_long_word();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule